// File: doc/BRIEF.md
# Character LCD Power-Up and Text Writer

This block brings up a two-line, sixteen-column character LCD module with an 8-bit parallel bus. It has no software interface. After reset it sends a fixed list of setup commands, then copies two text strings from its inputs onto the display, one string per row, and then stops. Each byte goes out as one bus transfer. A transfer has three phases:

- Register select and data are set up while the enable strobe is low.
- Enable is held high for a set number of clock cycles.
- The bus rests for a settle time.

Clear and cursor-home need a long settle. Every other byte uses a short settle. All timing is given in clock cycles through parameters, so the user sets them from the clock rate. With a 50 MHz clock, the values are about 1.6 ms and 40 µs, that is 80,000 and 2,000 cycles.

The strings arrive as packed vectors. Character k of a row is held in bits [8k+7:8k], so character 0 is the low byte. No stream interface is involved: the text inputs are plain levels read at the moment each character goes out, and the outputs are pin-level LCD signals. When the last character has settled, the block drives a `done` flag and stays quiet until the next reset.

Top module: `lcd_init_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `lcd_en`, `lcd_rs`, `lcd_rw` and `done` are 0 and `lcd_data` is 8'h00.
- R2: The first four transfers after reset are commands carrying 8'h38: three wake-up writes and then the function-set write (8-bit bus, two lines).
- R3: The next five commands go out in this order: 8'h08 (display off), 8'h01 (clear), 8'h02 (home), 8'h0C (display on, cursor hidden), 8'h06 (entry mode, increment). Clear therefore comes before any character.
- R4: Command transfers have `lcd_rs`=0. Character transfers have `lcd_rs`=1. `lcd_rw` is 0 on every transfer.
- R5: After the setup commands, the COLS bytes of `line0_text` are written as characters, lowest byte first.
- R6: When the row-one character index reaches its last column, the next transfer is command 8'hC0 (address of row two). The COLS bytes of `line1_text` follow, lowest byte first. A character byte equal to a command code is still sent as a character.
- R7: `lcd_en` stays high for exactly EN_CYC cycles per transfer. `lcd_rs` and `lcd_data` do not change while it is high.
- R8: From the fall of `lcd_en` to its next rise there are at least SETUP_CYC plus the settle count. The settle count is LONG_WAIT after 8'h01 or 8'h02 sent as commands, and SHORT_WAIT after any other transfer.
- R9: After the final character has settled, `done` goes to 1 and stays there. `lcd_en` stays 0, and no further transfer happens even if the text inputs change.
- R10: A reset asserted in the middle of the sequence stops it. After release, the sequence starts again from the first wake-up write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line0_text | input | COLS*8 | Row-one text, character 0 in the low byte |
| line1_text | input | COLS*8 | Row-two text, character 0 in the low byte |
| lcd_data | output | 8 | LCD data bus |
| lcd_rs | output | 1 | Register select: 0 command, 1 character |
| lcd_rw | output | 1 | Read/write select, always write (0) |
| lcd_en | output | 1 | Enable strobe |
| done | output | 1 | Sequence finished, held until reset |

## Verification
Two events can fall in the same cycle:

- At the end of row one, the index compare that picks the row-change command resolves in the same cycle as the settle of the last row-one character.
- At the very end, entering the hold state coincides with the settle of the final character.

To provoke the first case, one run fills the last column of row one with byte 8'hC0 and the first column of row two with 8'h01. These bytes can only be told apart from the row-change and clear commands by the register-select level and by their position in the stream. The scoreboard checks each transfer against the expected register-select and data pair. It also checks that `done` rises only once the expected queue is empty and that the bus then stays idle.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [3:0] {
    ST_WAKE1, ST_WAKE2, ST_WAKE3, ST_FUNC, ST_DOFF, ST_CLR, ST_HOME,
    ST_DON, ST_MODE, ST_ROW0, ST_ROWCHG, ST_ROW1, ST_HOLD
  } step_e;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_SETTLE} phase_e;

  localparam logic [7:0] CMD_WAKE   = 8'h38;
  localparam logic [7:0] CMD_FUNC   = 8'h38;
  localparam logic [7:0] CMD_DOFF   = 8'h08;
  localparam logic [7:0] CMD_CLEAR  = 8'h01;
  localparam logic [7:0] CMD_HOME   = 8'h02;
  localparam logic [7:0] CMD_DON    = 8'h0C;
  localparam logic [7:0] CMD_ENTRY  = 8'h06;
  localparam logic [7:0] CMD_ROW2   = 8'hC0;

  typedef struct packed {
    logic       rs;
    logic [7:0] data;
    logic       long_wait;
  } xfer_t;

endpackage

// File: rtl/lcd_char_pick.sv
module lcd_char_pick #(
  parameter int COLS  = 16,
  parameter int IDX_W = 5
) (
  input  logic [2*COLS*8-1:0] text_all,
  input  logic [IDX_W-1:0]    idx,
  output logic [7:0]          ch
);
  localparam int SLOTS = 2 * COLS;

  logic [7:0] slot [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot[g] = text_all[g*8 +: 8];
  end

  always_comb begin
    ch = 8'h00;
    if (int'(idx) < SLOTS) ch = slot[idx];
  end
endmodule

// File: rtl/lcd_step_decode.sv
module lcd_step_decode
  import lcd_seq_pkg::*;
(
  input  step_e      step,
  input  logic [7:0] ch,
  output xfer_t      req
);
  always_comb begin
    req = '{rs: 1'b0, data: 8'h00, long_wait: 1'b0};
    unique case (step)
      ST_WAKE1, ST_WAKE2, ST_WAKE3: req.data = CMD_WAKE;
      ST_FUNC:   req.data = CMD_FUNC;
      ST_DOFF:   req.data = CMD_DOFF;
      ST_CLR:    begin req.data = CMD_CLEAR; req.long_wait = 1'b1; end
      ST_HOME:   begin req.data = CMD_HOME;  req.long_wait = 1'b1; end
      ST_DON:    req.data = CMD_DON;
      ST_MODE:   req.data = CMD_ENTRY;
      ST_ROW0, ST_ROW1: begin req.rs = 1'b1; req.data = ch; end
      ST_ROWCHG: req.data = CMD_ROW2;
      default:   req.data = 8'h00;
    endcase
  end
endmodule

// File: rtl/lcd_bus_xfer.sv
module lcd_bus_xfer
  import lcd_seq_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int EN_CYC     = 12,
  parameter int SHORT_WAIT = 2000,
  parameter int LONG_WAIT  = 80000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  xfer_t      req,
  output logic [7:0] lcd_data,
  output logic       lcd_rs,
  output logic       lcd_en,
  output logic       xfer_done
);
  localparam int MAX_A = (SETUP_CYC > EN_CYC) ? SETUP_CYC : EN_CYC;
  localparam int MAX_B = (SHORT_WAIT > LONG_WAIT) ? SHORT_WAIT : LONG_WAIT;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAXC + 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             long_q;
  logic             cnt_zero;

  assign cnt_zero  = (cnt == '0);
  assign lcd_en    = (phase == PH_PULSE);
  assign xfer_done = (phase == PH_SETTLE) && cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      long_q   <= 1'b0;
      lcd_data <= 8'h00;
      lcd_rs   <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          lcd_data <= req.data;
          lcd_rs   <= req.rs;
          long_q   <= req.long_wait;
          cnt      <= CNT_W'(SETUP_CYC - 1);
          phase    <= PH_SETUP;
        end
        PH_SETUP: if (cnt_zero) begin
          cnt   <= CNT_W'(EN_CYC - 1);
          phase <= PH_PULSE;
        end else cnt <= cnt - 1'b1;
        PH_PULSE: if (cnt_zero) begin
          cnt   <= long_q ? CNT_W'(LONG_WAIT - 1) : CNT_W'(SHORT_WAIT - 1);
          phase <= PH_SETTLE;
        end else cnt <= cnt - 1'b1;
        PH_SETTLE: if (cnt_zero) phase <= PH_IDLE;
                   else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_seq_pkg::*;
#(
  parameter int COLS       = 16,
  parameter int SETUP_CYC  = 2,
  parameter int EN_CYC     = 12,
  parameter int SHORT_WAIT = 2000,
  parameter int LONG_WAIT  = 80000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COLS*8-1:0] line0_text,
  input  logic [COLS*8-1:0] line1_text,
  output logic [7:0]        lcd_data,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic              lcd_en,
  output logic              done
);
  localparam int IDX_W = $clog2(2 * COLS);
  localparam logic [IDX_W-1:0] LAST0 = IDX_W'(COLS - 1);
  localparam logic [IDX_W-1:0] LAST1 = IDX_W'(2 * COLS - 1);

  step_e            step, step_nxt;
  logic [IDX_W-1:0] idx;
  logic             wait_q;
  logic             start;
  logic             xfer_done;
  logic [7:0]       ch;
  xfer_t            req;

  lcd_char_pick #(.COLS(COLS), .IDX_W(IDX_W)) u_pick (
    .text_all ({line1_text, line0_text}),
    .idx      (idx),
    .ch       (ch)
  );

  lcd_step_decode u_dec (
    .step (step),
    .ch   (ch),
    .req  (req)
  );

  lcd_bus_xfer #(
    .SETUP_CYC(SETUP_CYC), .EN_CYC(EN_CYC),
    .SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)
  ) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req       (req),
    .lcd_data  (lcd_data),
    .lcd_rs    (lcd_rs),
    .lcd_en    (lcd_en),
    .xfer_done (xfer_done)
  );

  always_comb begin
    unique case (step)
      ST_ROW0:   step_nxt = (idx == LAST0) ? ST_ROWCHG : ST_ROW0;
      ST_ROW1:   step_nxt = (idx == LAST1) ? ST_HOLD : ST_ROW1;
      ST_ROWCHG: step_nxt = ST_ROW1;
      ST_HOLD:   step_nxt = ST_HOLD;
      default:   step_nxt = step_e'(step + 4'd1);
    endcase
  end

  assign start  = !wait_q && (step != ST_HOLD);
  assign done   = (step == ST_HOLD);
  assign lcd_rw = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step   <= ST_WAKE1;
      idx    <= '0;
      wait_q <= 1'b0;
    end else if (step != ST_HOLD) begin
      if (!wait_q) begin
        wait_q <= 1'b1;
      end else if (xfer_done) begin
        wait_q <= 1'b0;
        step   <= step_nxt;
        if (step == ST_ROW0 || step == ST_ROW1) idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk #(
  parameter int SETUP_CYC  = 2,
  parameter int EN_CYC     = 12,
  parameter int SHORT_WAIT = 2000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       lcd_en,
  input logic       lcd_rs,
  input logic [7:0] lcd_data,
  input logic       done
);
  logic [31:0] hi_cnt, lo_cnt;
  logic        seen_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt    <= '0;
      lo_cnt    <= '0;
      seen_fall <= 1'b0;
    end else begin
      if (lcd_en) begin
        hi_cnt <= hi_cnt + 1;
        lo_cnt <= '0;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != 32'hFFFF_FFFF) lo_cnt <= lo_cnt + 1;
        if (hi_cnt != 0) seen_fall <= 1'b1;
      end
    end
  end

  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_en) |-> hi_cnt == 32'(EN_CYC));

  assert_bus_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en && $past(lcd_en)) |-> ($stable(lcd_data) && $stable(lcd_rs)));

  assert_min_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lcd_en) && seen_fall) |-> lo_cnt >= 32'(SHORT_WAIT + SETUP_CYC));

  assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !lcd_en);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

bind lcd_init_seq lcd_init_seq_chk #(
  .SETUP_CYC(SETUP_CYC), .EN_CYC(EN_CYC), .SHORT_WAIT(SHORT_WAIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lcd_en(lcd_en), .lcd_rs(lcd_rs),
  .lcd_data(lcd_data), .done(done)
);

// File: tb/lcd_init_seq_tb.sv
module lcd_init_seq_tb;
  localparam int COLS  = 16;
  localparam int SETUP = 2;
  localparam int EN    = 3;
  localparam int SHORT = 10;
  localparam int LONG  = 40;
  localparam int TOTAL = 9 + 2 * COLS + 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n = 1'b0;
  logic [COLS*8-1:0] l0, l1;
  logic [7:0]        lcd_data;
  logic              lcd_rs, lcd_rw, lcd_en, done;

  lcd_init_seq #(
    .COLS(COLS), .SETUP_CYC(SETUP), .EN_CYC(EN),
    .SHORT_WAIT(SHORT), .LONG_WAIT(LONG)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .line0_text(l0), .line1_text(l1),
    .lcd_data(lcd_data), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_en(lcd_en), .done(done)
  );

  typedef struct {
    logic       rs;
    logic [7:0] d;
    string      tag;
  } item_t;

  item_t exp_q[$];
  item_t it;
  int n_chk = 0, n_bad = 0, writes = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  function automatic void push(input logic rs, input logic [7:0] d, input string tag);
    item_t e;
    e.rs = rs; e.d = d; e.tag = tag;
    exp_q.push_back(e);
  endfunction

  function automatic logic [COLS*8-1:0] make_line(input logic [7:0] base);
    logic [COLS*8-1:0] r;
    for (int k = 0; k < COLS; k++) r[k*8 +: 8] = base + 8'(k);
    return r;
  endfunction

  // driver side of the scoreboard: expected transfer list from R2..R6
  task automatic load_expected(input logic [COLS*8-1:0] a, input logic [COLS*8-1:0] b);
    for (int k = 0; k < 4; k++) push(1'b0, 8'h38, "R2");
    push(1'b0, 8'h08, "R3"); push(1'b0, 8'h01, "R3"); push(1'b0, 8'h02, "R3");
    push(1'b0, 8'h0C, "R3"); push(1'b0, 8'h06, "R3");
    for (int k = 0; k < COLS; k++) push(1'b1, a[k*8 +: 8], "R5");
    push(1'b0, 8'hC0, "R6");
    for (int k = 0; k < COLS; k++) push(1'b1, b[k*8 +: 8], "R6");
  endtask

  // monitor side of the scoreboard
  logic       en_q = 1'b0;
  int         hi_n = 0, lo_n = 0;
  bit         have_prev = 0, prev_long = 0;
  logic [7:0] cap_d;
  logic       cap_rs;

  always @(negedge clk) begin
    if (!rst_n) begin
      en_q = 1'b0; hi_n = 0; lo_n = 0; have_prev = 0;
    end else begin
      if (lcd_en && !en_q) begin
        writes++;
        chk(lcd_rw == 1'b0, "R4", "rw level", lcd_rw, 0);
        if (have_prev)
          chk(lo_n >= (prev_long ? LONG : SHORT) + SETUP, "R8", "low gap",
              lo_n, (prev_long ? LONG : SHORT) + SETUP);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "write after finish", {lcd_rs, lcd_data}, 0);
        end else begin
          it = exp_q.pop_front();
          chk(lcd_rs == it.rs, "R4", "rs level", lcd_rs, it.rs);
          chk(lcd_data == it.d, it.tag, "data byte", lcd_data, it.d);
        end
        prev_long = !lcd_rs && (lcd_data == 8'h01 || lcd_data == 8'h02);
        cap_d = lcd_data; cap_rs = lcd_rs; hi_n = 1; have_prev = 1;
      end else if (lcd_en) begin
        hi_n++;
        if (lcd_data !== cap_d || lcd_rs !== cap_rs)
          chk(1'b0, "R7", "bus moved under enable", lcd_data, cap_d);
      end else if (en_q) begin
        chk(hi_n == EN, "R7", "enable width", hi_n, EN);
        lo_n = 1;
      end else begin
        lo_n++;
      end
      en_q = lcd_en;
    end
  end

  task automatic wait_done();
    int t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R9", "done flag", done, 1);
    chk(exp_q.size() == 0, "R9", "queue left at done", exp_q.size(), 0);
    chk(writes == TOTAL, "R9", "transfer count", writes, TOTAL);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    l0 = make_line(8'h41);
    l1 = make_line(8'h61);
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(lcd_en == 1'b0, "R1", "en in reset", lcd_en, 0);
    chk(lcd_rs == 1'b0, "R1", "rs in reset", lcd_rs, 0);
    chk(lcd_rw == 1'b0, "R1", "rw in reset", lcd_rw, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    chk(lcd_data == 8'h00, "R1", "data in reset", lcd_data, 0);
    load_expected(l0, l1);
    writes = 0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(lcd_en == 1'b0 && done == 1'b0, "R1", "first cycle after reset",
        {lcd_en, done}, 0);
    wait_done();

    // R9: text changes in hold have no effect
    l0 = make_line(8'h20);
    l1 = make_line(8'h50);
    repeat (200) @(negedge clk);
    chk(writes == TOTAL, "R9", "writes during hold", writes, TOTAL);
    chk(lcd_en == 1'b0, "R9", "en during hold", lcd_en, 0);
    chk(done == 1'b1, "R9", "done during hold", done, 1);

    // R10: reset part way through, with bytes that look like commands (R6)
    rst_n = 1'b0;
    l0 = make_line(8'h30);
    l0[(COLS-1)*8 +: 8] = 8'hC0;
    l1 = make_line(8'h70);
    l1[7:0] = 8'h01;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R10", "done cleared by reset", done, 0);
    load_expected(l0, l1);
    writes = 0;
    rst_n = 1'b1;
    wait (writes == 12);
    @(negedge lcd_en);
    @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    chk(lcd_en == 1'b0 && done == 1'b0, "R10", "idle after mid reset",
        {lcd_en, done}, 0);
    load_expected(l0, l1);
    writes = 0;
    rst_n = 1'b1;
    wait_done();

    summary();
    $finish;
  end
endmodule